// File: doc/BRIEF.md
# Paged Command Register Decoder

This block takes 16-bit command words that a serial front end has already assembled. It turns each one into a single byte write on a small paged register file. Every word has three fields. The top bit is a write flag, the next seven bits are a byte address and the low eight bits are a data value. Byte address zero holds a page selector, and that selector is decoded on every page. All other addresses are matched only when the selected page equals the configured target page. Each 16-bit register takes two byte addresses: the low byte sits at the even address and the high byte at the odd address above it.

On the target page there are three registers. The function-control register is at byte address 0x06, the general-purpose I/O control register at 0x08 and the sleep-count register at 0x10. Their complete 16-bit values, and the current page, drive downstream logic directly. Bits with no defined meaning are held at zero. A write to an address with no register behind it is dropped.

Words arrive on a valid/ready stream. Ready is held high, so the block never applies back-pressure. A word is taken on every rising clock edge at which valid is high. A word that is presented while valid is low is not taken and has no effect.

Top module: `pcd_decoder`

## Requirements
- R1: After reset the page is 0x00, the function-control register is 0x000D, and the I/O control and sleep-count registers are 0x0000.
- R2: An accepted word with bit 15 = 0 changes neither the page nor any register.
- R3: An accepted write (bit 15 = 1) to byte address 0x00 (bits [14:8]) loads the data byte (bits [7:0]) into the page, whatever the current page is.
- R4: On page 3, a write to the even base address (0x06, 0x08 or 0x10) replaces the register's low byte, and a write to the base address + 1 replaces its high byte. The register's other byte is left unchanged.
- R5: Undefined bits always read as 0. The function-control register keeps bits [11:0], the I/O control register keeps bits [7:0] and the sleep-count register keeps bits [9:0].
- R6: When the page is not 3, writes to any non-zero address leave all three registers unchanged.
- R7: On page 3, writes to addresses that hold no register byte (including 0x01) leave the page and all three registers unchanged.
- R8: cmd_ready is always 1. A word presented while cmd_valid is low is not taken and changes nothing.
- R9: A write takes effect at the rising edge that accepts it and is visible on the outputs before the next rising edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | Command word valid |
| cmd_ready | output | 1 | Always high; the block never stalls |
| cmd_word | input | 16 | Write flag [15], byte address [14:8], data [7:0] |
| page_o | output | 8 | Current page |
| func_ctrl_o | output | 16 | Function-control register (page 3, 0x06/0x07) |
| gpio_ctrl_o | output | 16 | I/O control register (page 3, 0x08/0x09) |
| sleep_ctrl_o | output | 16 | Sleep-count register (page 3, 0x10/0x11) |

## Verification
Every result of this block is due after exactly one register stage. A word accepted at a rising edge shows up on the page and register outputs straight after that edge. The bench drives each word at a falling edge and drops valid at the next falling edge. It compares all four outputs against its own model at that point, half a cycle after the edge that accepted the word and before any later edge. The sweep visits every byte address on pages 0 to 4, then repeats the sweep with the write flag clear and with valid low, so that no address is left out.

// File: rtl/pcd_pkg.sv
package pcd_pkg;
  localparam int CMD_W  = 16;
  localparam int ADDR_W = 7;
  localparam int DATA_W = 8;
  localparam int REG_W  = 2 * DATA_W;
  localparam int NREG   = 3;

  typedef struct packed {
    logic              wr;
    logic [ADDR_W-1:0] addr;
    logic [DATA_W-1:0] data;
  } cmd_t;

  // register table: index 0 function control, 1 I/O control, 2 sleep count
  function automatic logic [ADDR_W-1:0] reg_base(int idx);
    case (idx)
      0:       return ADDR_W'(7'h06);
      1:       return ADDR_W'(7'h08);
      default: return ADDR_W'(7'h10);
    endcase
  endfunction

  function automatic logic [REG_W-1:0] reg_mask(int idx);
    case (idx)
      0:       return REG_W'(16'h0FFF);
      1:       return REG_W'(16'h00FF);
      default: return REG_W'(16'h03FF);
    endcase
  endfunction

  function automatic logic [REG_W-1:0] reg_rst(int idx);
    case (idx)
      0:       return REG_W'(16'h000D);
      default: return REG_W'(16'h0000);
    endcase
  endfunction
endpackage

// File: rtl/pcd_cmd_split.sv
module pcd_cmd_split
  import pcd_pkg::*;
(
  input  logic              valid,
  input  logic [CMD_W-1:0]  word,
  output logic              wr_en,
  output logic [ADDR_W-1:0] addr,
  output logic [DATA_W-1:0] data
);
  cmd_t c;
  always_comb begin
    c     = cmd_t'(word);
    wr_en = valid && c.wr;
    addr  = c.addr;
    data  = c.data;
  end
endmodule

// File: rtl/pcd_page_reg.sv
module pcd_page_reg
  import pcd_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] data,
  output logic [DATA_W-1:0] page
);
  logic hit;
  assign hit = wr_en && (addr == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   page <= '0;
    else if (hit) page <= data;
  end
endmodule

// File: rtl/pcd_reg16.sv
module pcd_reg16
  import pcd_pkg::*;
#(
  parameter logic [ADDR_W-1:0] BASE     = '0,
  parameter logic [REG_W-1:0]  MASK     = '1,
  parameter logic [REG_W-1:0]  RST_VAL  = '0,
  parameter logic [DATA_W-1:0] PAGE_SEL = 8'd3
)(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] data,
  input  logic [DATA_W-1:0] page,
  output logic [REG_W-1:0]  q
);
  localparam logic [ADDR_W-1:0] HI_ADDR = BASE | ADDR_W'(1);
  localparam logic [REG_W-1:0]  RST_M   = RST_VAL & MASK;

  logic on_page, hit_lo, hit_hi;
  assign on_page = wr_en && (page == PAGE_SEL);
  assign hit_lo  = on_page && (addr == BASE);
  assign hit_hi  = on_page && (addr == HI_ADDR);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q <= RST_M;
    end else begin
      if (hit_lo) q[DATA_W-1:0]     <= data & MASK[DATA_W-1:0];
      if (hit_hi) q[REG_W-1:DATA_W] <= data & MASK[REG_W-1:DATA_W];
    end
  end
endmodule

// File: rtl/pcd_decoder.sv
module pcd_decoder
  import pcd_pkg::*;
#(
  parameter logic [DATA_W-1:0] TARGET_PAGE = 8'd3
)(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_valid,
  output logic              cmd_ready,
  input  logic [CMD_W-1:0]  cmd_word,
  output logic [DATA_W-1:0] page_o,
  output logic [REG_W-1:0]  func_ctrl_o,
  output logic [REG_W-1:0]  gpio_ctrl_o,
  output logic [REG_W-1:0]  sleep_ctrl_o
);
  logic              wr_en;
  logic [ADDR_W-1:0] addr;
  logic [DATA_W-1:0] data;
  logic [REG_W-1:0]  reg_q [NREG];

  assign cmd_ready = 1'b1;

  pcd_cmd_split u_split (
    .valid (cmd_valid), .word (cmd_word),
    .wr_en (wr_en), .addr (addr), .data (data)
  );

  pcd_page_reg u_page (
    .clk (clk), .rst_n (rst_n), .wr_en (wr_en),
    .addr (addr), .data (data), .page (page_o)
  );

  for (genvar i = 0; i < NREG; i++) begin : g_reg
    pcd_reg16 #(
      .BASE     (reg_base(i)),
      .MASK     (reg_mask(i)),
      .RST_VAL  (reg_rst(i)),
      .PAGE_SEL (TARGET_PAGE)
    ) u_reg (
      .clk (clk), .rst_n (rst_n), .wr_en (wr_en),
      .addr (addr), .data (data), .page (page_o),
      .q (reg_q[i])
    );
  end

  assign func_ctrl_o  = reg_q[0];
  assign gpio_ctrl_o  = reg_q[1];
  assign sleep_ctrl_o = reg_q[2];
endmodule

// File: rtl/pcd_decoder_chk.sv
module pcd_decoder_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        cmd_valid,
  input logic        cmd_ready,
  input logic [15:0] cmd_word,
  input logic [7:0]  page_o,
  input logic [15:0] func_ctrl_o,
  input logic [15:0] gpio_ctrl_o,
  input logic [15:0] sleep_ctrl_o
);
  logic [55:0] all_state;
  assign all_state = {page_o, func_ctrl_o, gpio_ctrl_o, sleep_ctrl_o};

  assert_no_write_flag_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && !cmd_word[15]) |=> $stable(all_state));

  assert_page_load_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_word[15] && cmd_word[14:8] == 7'h00) |=> (page_o == $past(cmd_word[7:0])));

  assert_unused_zero_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (func_ctrl_o[15:12] == 4'h0) && (gpio_ctrl_o[15:8] == 8'h00) && (sleep_ctrl_o[15:10] == 6'h00));

  assert_off_page_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_word[15] && cmd_word[14:8] != 7'h00 && page_o != 8'd3)
      |=> $stable({func_ctrl_o, gpio_ctrl_o, sleep_ctrl_o}));

  assert_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !cmd_valid |=> $stable(all_state));

  assert_ready_high_R8: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid |-> cmd_ready);
endmodule

bind pcd_decoder pcd_decoder_chk u_chk (
  .clk (clk), .rst_n (rst_n), .cmd_valid (cmd_valid), .cmd_ready (cmd_ready),
  .cmd_word (cmd_word), .page_o (page_o), .func_ctrl_o (func_ctrl_o),
  .gpio_ctrl_o (gpio_ctrl_o), .sleep_ctrl_o (sleep_ctrl_o)
);

// File: tb/tb_pcd_decoder.sv
module tb_pcd_decoder;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cmd_valid = 1'b0;
  logic        cmd_ready;
  logic [15:0] cmd_word = '0;
  logic [7:0]  page_o;
  logic [15:0] func_ctrl_o, gpio_ctrl_o, sleep_ctrl_o;

  int n_chk = 0;
  int n_err = 0;
  logic done = 1'b0;

  logic [7:0]  m_page;
  logic [15:0] m_fn, m_gp, m_sl;

  always #4 clk = ~clk;

  pcd_decoder dut (
    .clk (clk), .rst_n (rst_n), .cmd_valid (cmd_valid), .cmd_ready (cmd_ready),
    .cmd_word (cmd_word), .page_o (page_o), .func_ctrl_o (func_ctrl_o),
    .gpio_ctrl_o (gpio_ctrl_o), .sleep_ctrl_o (sleep_ctrl_o)
  );

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic chk_all(input string tag);
    chk(tag, {8'h00, page_o, func_ctrl_o, gpio_ctrl_o, sleep_ctrl_o},
             {8'h00, m_page, m_fn, m_gp, m_sl});
    chk({tag, " ready R8"}, {63'd0, cmd_ready}, 64'd1);
  endtask

  // model from the requirements (R3..R7)
  task automatic model(input logic [15:0] w);
    logic [6:0] a;
    logic [7:0] d;
    a = w[14:8];
    d = w[7:0];
    if (w[15]) begin
      if (a == 7'h00) m_page = d;
      else if (m_page == 8'd3) begin
        case (a)
          7'h06: m_fn[7:0]  = d;
          7'h07: m_fn[15:8] = d & 8'h0F;
          7'h08: m_gp[7:0]  = d;
          7'h09: m_gp[15:8] = 8'h00;
          7'h10: m_sl[7:0]  = d;
          7'h11: m_sl[15:8] = d & 8'h03;
          default: ;
        endcase
      end
    end
  endtask

  task automatic send(input logic v, input logic [15:0] w, input string tag);
    @(negedge clk);
    cmd_valid = v;
    cmd_word  = w;
    @(negedge clk);
    cmd_valid = 1'b0;
    if (v) model(w);
    chk_all(tag);
  endtask

  initial begin
    #(200000 * 8);
    if (!done) begin
      n_chk++;
      n_err++;
      $display("FAIL watchdog R9 actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

  initial begin
    m_page = 8'h00; m_fn = 16'h000D; m_gp = 16'h0000; m_sl = 16'h0000;
    repeat (3) @(negedge clk);
    chk_all("reset R1");
    rst_n = 1'b1;
    @(negedge clk);
    chk_all("after reset R1");

    // R4 / R5 / R9: explicit page-3 writes with all-ones data
    send(1'b1, 16'h8003, "page to 3 R3");
    send(1'b1, 16'h86FF, "fn low R4");
    send(1'b1, 16'h87FF, "fn high mask R5");
    send(1'b1, 16'h89FF, "gpio high mask R5");
    send(1'b1, 16'h91FF, "sleep high mask R5");
    send(1'b1, 16'h9064, "sleep low R4 R9");
    send(1'b1, 16'h81AA, "addr 0x01 ignored R7");

    // sweep pages 0..4, every byte address
    for (int pg = 0; pg < 5; pg++) begin
      send(1'b1, {1'b1, 7'h00, 8'(pg)}, "page select R3");
      for (int a = 1; a < 128; a++) begin
        send(1'b1, {1'b1, 7'(a), 8'((a * 37 + pg * 11) & 8'hFF)},
             (pg == 3) ? "page3 sweep R4 R7" : "off-page sweep R6");
      end
    end

    // write flag clear: nothing changes
    send(1'b1, 16'h8003, "page back to 3 R3");
    for (int a = 0; a < 128; a++)
      send(1'b1, {1'b0, 7'(a), 8'hA5}, "no write flag R2");

    // valid low: nothing taken
    for (int a = 0; a < 128; a++)
      send(1'b0, {1'b1, 7'(a), 8'h5A}, "valid low R8");

    // page switch away and back under write
    send(1'b1, 16'h8007, "page 7 R3");
    send(1'b1, 16'h8612, "page 7 ignored R6");
    send(1'b1, 16'h8003, "page 3 again R3");
    send(1'b1, 16'h8612, "fn low again R4");

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule